// File: doc/BRIEF.md
# Packed float-to-unsigned-64 converter

This block turns a vector of up to eight single-precision floating-point lanes into unsigned 64-bit integers. Source lane j (32 bits) produces destination lane j (64 bits). A length select picks 2, 4 or 8 active lanes. Any destination bit above the selected length is cleared. A per-lane write mask chooses which lanes take the converted value. A lane whose mask bit is clear either keeps the old destination lane or is zeroed. A broadcast option makes every lane convert source element 0.

Rounding normally follows a global two-bit control. A per-operation override is used only at full width with a register source and the broadcast/rounding bit set. When that bit is set with a memory source, it means broadcast. Values that cannot be represented saturate to all ones and raise the invalid flag. A result that is rounded but valid raises the precision flag. Each operation starts on a one-cycle strobe. The result, the flags and a done pulse are registered on the next clock.

Top module: `fp32_to_u64_vec`

## Requirements
- R1: `vlen_sel` 00 selects 2 active lanes, 01 selects 4, and 10 or 11 selects 8. Every result bit at or above 128 × (number of active lanes ÷ 2) reads 0, whatever `old_dst` holds.
- R2: Each written lane holds the integer value of its 32-bit source element `src[32j+31:32j]`, placed at `result[64j+63:64j]`. In-range integral inputs convert exactly, up to 0xFFFFFF0000000000.
- R3: The rounding code is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. For example, 2.5 gives 2, 2, 3 and 2 in those four modes.
- R4: `rnd_embed` replaces `rnd_global` only when `vlen_sel` selects 8 lanes, `src_is_mem`=0 and `bcast_rnd`=1. In every other case `rnd_global` is used.
- R5: NaN, either infinity, and any value that rounds to 2^64 or above give all ones in the lane and raise `flag_invalid`.
- R6: A negative value whose rounded magnitude is nonzero is invalid (all ones, `flag_invalid`). A negative value that rounds to zero gives 0 and is valid. Negative zero gives 0 with no flag.
- R7: Denormal inputs convert to 0 or 1 according to the rounding mode and raise `flag_precision`.
- R8: With `wmask_en`=0 every active lane is written. With `wmask_en`=1 only active lanes whose `wmask` bit is 1 are written.
- R9: An active lane that is not written keeps `old_dst` when `zero_fill`=0 and reads 0 when `zero_fill`=1.
- R10: With `src_is_mem`=1 and `bcast_rnd`=1, every written lane converts `src[31:0]`. With `src_is_mem`=0, each lane uses its own element.
- R11: `flag_invalid` and `flag_precision` are the OR over written lanes only. Precision means a lane was rounded and is not invalid.
- R12: Reset clears `result`, the flags and `done`. `result`, the flags and `done`=1 appear on the clock after a `start` strobe. `done` lasts one cycle, and `result` holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Strobe: convert the present inputs |
| src | input | 256 | Eight single-precision source lanes |
| old_dst | input | 512 | Prior destination, used by merge masking |
| wmask | input | 8 | Per-lane write mask |
| wmask_en | input | 1 | 1 = write mask in use |
| zero_fill | input | 1 | 1 = zero unwritten lanes, 0 = merge |
| vlen_sel | input | 2 | Vector length select |
| src_is_mem | input | 1 | Source comes from memory |
| bcast_rnd | input | 1 | Broadcast (memory source) or rounding override (register source) |
| rnd_global | input | 2 | Global rounding control |
| rnd_embed | input | 2 | Per-operation rounding override |
| result | output | 512 | Converted destination vector |
| flag_invalid | output | 1 | Invalid flag for the last operation |
| flag_precision | output | 1 | Precision flag for the last operation |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
Each lane's converter has no state of its own. A fault in its shift, rounding or invalid path therefore shows up in the result lane on the very clock after the strobe. A flipped active-lane count or mask decode shows up on that same cycle in the wrong lanes: upper lanes that are not zero, merged lanes that lost `old_dst`, or flags raised by masked-off lanes. A fault in the output register appears as a missing or stretched `done`, or as a result that drifts while no strobe is present.

// File: rtl/cvt_pkg.sv
// Shared constants and types for the float-to-unsigned-64 converter.
// Assumes IEEE-754 binary32 inputs and 64-bit unsigned outputs.
package cvt_pkg;
    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int MANT_W  = 23;
    localparam int SIG_W   = MANT_W + 1;
    localparam int INT_W   = 64;
    localparam int BIAS    = 127;
    localparam int INT_PT  = BIAS + MANT_W;       // exponent where the significand is an integer
    localparam int OVF_EXP = BIAS + INT_W;        // exponent giving 2^64
    localparam int GUARD   = 26;                  // right-shift clamp keeping round and sticky
    localparam int RSH_W   = $clog2(GUARD + 1);
    localparam int LSH_W   = $clog2(INT_W);

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_DOWN      = 2'b01,
        RND_UP        = 2'b10,
        RND_ZERO      = 2'b11
    } rnd_mode_t;
endpackage

// File: rtl/fcvt_lane.sv
// One lane: a binary32 value to an unsigned 64-bit integer, combinational.
// Assumes the rounding mode has already been chosen. Invalid saturates to all ones.
module fcvt_lane
    import cvt_pkg::*;
(
    input  logic [FP_W-1:0]  fp_in,
    input  rnd_mode_t        rmode,
    output logic [INT_W-1:0] int_out,
    output logic             invalid,
    output logic             inexact
);
    logic                      sgn;
    logic [EXP_W-1:0]          ex;
    logic [SIG_W-1:0]          sig;
    logic [EXP_W:0]            e_eff;
    logic                      big;
    logic [LSH_W-1:0]          lsh;
    logic [EXP_W:0]            rsh_full;
    logic [RSH_W-1:0]          rsh_c;
    logic [SIG_W+GUARD-1:0]    ext;
    logic [SIG_W-1:0]          ipart;
    logic                      rbit, stk, inc;
    logic [SIG_W:0]            mag;

    // Split the fields; denormals use exponent 1 with no hidden bit.
    always_comb begin
        sgn   = fp_in[FP_W-1];
        ex    = fp_in[FP_W-2:MANT_W];
        sig   = {|ex, fp_in[MANT_W-1:0]};
        e_eff = (ex == '0) ? (EXP_W+1)'(1) : {1'b0, ex};
    end

    // Align the significand: shift left for large values, right with round/sticky for small.
    always_comb begin
        big      = e_eff >= (EXP_W+1)'(INT_PT);
        lsh      = LSH_W'(e_eff - (EXP_W+1)'(INT_PT));
        rsh_full = (EXP_W+1)'(INT_PT) - e_eff;
        rsh_c    = (rsh_full > (EXP_W+1)'(GUARD)) ? RSH_W'(GUARD) : RSH_W'(rsh_full);
        ext      = {sig, {GUARD{1'b0}}} >> rsh_c;
        ipart    = ext[SIG_W+GUARD-1:GUARD];
        rbit     = ext[GUARD-1];
        stk      = |ext[GUARD-2:0];
    end

    // Choose the rounding increment for the magnitude.
    always_comb begin
        case (rmode)
            RND_NEAR_EVEN: inc = rbit & (stk | ipart[0]);
            RND_DOWN:      inc = sgn & (rbit | stk);
            RND_UP:        inc = ~sgn & (rbit | stk);
            default:       inc = 1'b0;
        endcase
        mag = {1'b0, ipart} + {{SIG_W{1'b0}}, inc};
    end

    // Classify the value and form the lane result and its flags.
    always_comb begin
        int_out = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (ex == '1) begin
            invalid = 1'b1;
        end else if (big) begin
            if (e_eff >= (EXP_W+1)'(OVF_EXP) || sgn)
                invalid = 1'b1;
            else
                int_out = {{(INT_W-SIG_W){1'b0}}, sig} << lsh;
        end else if (sgn && mag != '0) begin
            invalid = 1'b1;
        end else begin
            int_out = sgn ? '0 : {{(INT_W-SIG_W-1){1'b0}}, mag};
            inexact = rbit | stk;
        end
        if (invalid)
            int_out = '1;
    end

    // R2
    always_comb begin
        lane_small_chk: assert (sgn || ex >= EXP_W'(BIAS) || (int_out <= INT_W'(1) && !invalid));
    end
endmodule

// File: rtl/lane_pick.sv
// Write-mask resolution for one lane: converted value, old value or zero.
// Assumes `active` and `wr_en` are already decoded by the parent.
module lane_pick
    import cvt_pkg::*;
(
    input  logic [INT_W-1:0] conv,
    input  logic [INT_W-1:0] old,
    input  logic             active,
    input  logic             wr_en,
    input  logic             zero_fill,
    output logic [INT_W-1:0] lane_out
);
    // Select the lane's destination value.
    always_comb begin
        if (!active || (!wr_en && zero_fill))
            lane_out = '0;
        else if (wr_en)
            lane_out = conv;
        else
            lane_out = old;
    end
endmodule

// File: rtl/fp32_to_u64_vec.sv
// Packed float-to-unsigned-64 converter: per-lane converters, masking,
// broadcast and rounding selection, with a one-cycle registered result.
// Assumes LANES is a multiple of 4; start is a single-cycle strobe.
module fp32_to_u64_vec
    import cvt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES*FP_W-1:0]  src,
    input  logic [LANES*INT_W-1:0] old_dst,
    input  logic [LANES-1:0]       wmask,
    input  logic                   wmask_en,
    input  logic                   zero_fill,
    input  logic [1:0]             vlen_sel,
    input  logic                   src_is_mem,
    input  logic                   bcast_rnd,
    input  logic [1:0]             rnd_global,
    input  logic [1:0]             rnd_embed,
    output logic [LANES*INT_W-1:0] result,
    output logic                   flag_invalid,
    output logic                   flag_precision,
    output logic                   done
);
    localparam int SRC_W = LANES * FP_W;
    localparam int DST_W = LANES * INT_W;
    localparam int CW    = $clog2(LANES + 1);

    logic [CW-1:0]    nact;
    rnd_mode_t        rsel;
    logic             do_bcast;
    logic [DST_W-1:0] next_res;
    logic [LANES-1:0] inv_v, prec_v;

    // Decode the active lane count, the rounding source and broadcast.
    always_comb begin
        case (vlen_sel)
            2'b00:   nact = CW'(LANES / 4);
            2'b01:   nact = CW'(LANES / 2);
            default: nact = CW'(LANES);
        endcase
        rsel     = (vlen_sel[1] && !src_is_mem && bcast_rnd) ? rnd_mode_t'(rnd_embed)
                                                             : rnd_mode_t'(rnd_global);
        do_bcast = src_is_mem & bcast_rnd;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [FP_W-1:0]  l_src;
        logic [INT_W-1:0] l_conv;
        logic             l_act, l_wr, l_inv, l_inex;

        assign l_src = do_bcast ? src[FP_W-1:0] : src[j*FP_W +: FP_W];
        assign l_act = CW'(j) < nact;
        assign l_wr  = l_act & (~wmask_en | wmask[j]);

        fcvt_lane u_cvt (
            .fp_in   (l_src),
            .rmode   (rsel),
            .int_out (l_conv),
            .invalid (l_inv),
            .inexact (l_inex)
        );

        lane_pick u_pick (
            .conv      (l_conv),
            .old       (old_dst[j*INT_W +: INT_W]),
            .active    (l_act),
            .wr_en     (l_wr),
            .zero_fill (zero_fill),
            .lane_out  (next_res[j*INT_W +: INT_W])
        );

        assign inv_v[j]  = l_wr & l_inv;
        assign prec_v[j] = l_wr & l_inex;
    end

    // Register the result and flags on a strobe; done pulses one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result         <= '0;
            flag_invalid   <= 1'b0;
            flag_precision <= 1'b0;
            done           <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                result         <= next_res;
                flag_invalid   <= |inv_v;
                flag_precision <= |prec_v;
            end
        end
    end

    // R12
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R12
    done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && vlen_sel == 2'b00) |=> (result[DST_W-1:DST_W/4] == '0));
    // R9
    merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wmask_en && !zero_fill && !wmask[0]) |=> (result[INT_W-1:0] == $past(old_dst[INT_W-1:0])));
    // R9
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wmask_en && zero_fill && !wmask[0]) |=> (result[INT_W-1:0] == '0));
    // R11
    masked_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && wmask_en && wmask == '0) |=> (!flag_invalid && !flag_precision));

    logic unused_src_w;
    assign unused_src_w = (SRC_W == 0);
endmodule

// File: tb/fp32_to_u64_vec_bench.sv
module fp32_to_u64_vec_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [1:0]  rc;
        logic [63:0] ea;
        logic [63:0] eb;
        logic        inv;
        logic        prec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h3F800000, 32'h4F000000, 2'd0, 64'd1, 64'h80000000, 1'b0, 1'b0, 4'd2},           // R2
        '{32'h40200000, 32'h40600000, 2'd0, 64'd2, 64'd4, 1'b0, 1'b1, 4'd3},                   // R3
        '{32'h40200000, 32'h3FC00000, 2'd1, 64'd2, 64'd1, 1'b0, 1'b1, 4'd3},
        '{32'h40200000, 32'h3FC00000, 2'd2, 64'd3, 64'd2, 1'b0, 1'b1, 4'd3},
        '{32'h40200000, 32'h40600000, 2'd3, 64'd2, 64'd3, 1'b0, 1'b1, 4'd3},
        '{32'hBF000000, 32'h00000000, 2'd0, 64'd0, 64'd0, 1'b0, 1'b1, 4'd6},                   // R6
        '{32'hBF000000, 32'h3F800000, 2'd1, '1, 64'd1, 1'b1, 1'b0, 4'd6},
        '{32'hBF800000, 32'h80000000, 2'd3, '1, 64'd0, 1'b1, 1'b0, 4'd6},
        '{32'h7FC00000, 32'h7F800000, 2'd0, '1, '1, 1'b1, 1'b0, 4'd5},                         // R5
        '{32'h5F800000, 32'h5F7FFFFF, 2'd0, '1, 64'hFFFFFF0000000000, 1'b1, 1'b0, 4'd5},
        '{32'h00000001, 32'h3F800000, 2'd0, 64'd0, 64'd1, 1'b0, 1'b1, 4'd7},                   // R7
        '{32'h00000001, 32'h80000001, 2'd2, 64'd1, 64'd0, 1'b0, 1'b1, 4'd7},
        '{32'h3F400000, 32'h80000000, 2'd3, 64'd0, 64'd0, 1'b0, 1'b1, 4'd3}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] src = '0;
    logic [511:0] old_dst = '0;
    logic [7:0]   wmask = '0;
    logic         wmask_en = 1'b0;
    logic         zero_fill = 1'b0;
    logic [1:0]   vlen_sel = '0;
    logic         src_is_mem = 1'b0;
    logic         bcast_rnd = 1'b0;
    logic [1:0]   rnd_global = '0;
    logic [1:0]   rnd_embed = '0;
    logic [511:0] result;
    logic         flag_invalid, flag_precision, done;

    int checks = 0;
    int errors = 0;
    logic [511:0] held;

    fp32_to_u64_vec u_fp32_to_u64_vec (
        .clk(clk), .rst_n(rst_n), .start(start), .src(src), .old_dst(old_dst),
        .wmask(wmask), .wmask_en(wmask_en), .zero_fill(zero_fill), .vlen_sel(vlen_sel),
        .src_is_mem(src_is_mem), .bcast_rnd(bcast_rnd), .rnd_global(rnd_global),
        .rnd_embed(rnd_embed), .result(result), .flag_invalid(flag_invalid),
        .flag_precision(flag_precision), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane(input logic [511:0] r, input int j);
        return r[j*64 +: 64];
    endfunction

    task automatic fire();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic fill_old();
        for (int j = 0; j < 8; j++) old_dst[j*64 +: 64] = 64'hA5A5_0000_0000_0000 | 64'(j);
    endtask

    task automatic fill_ints();
        for (int j = 0; j < 8; j++) src[j*32 +: 32] = 32'h3F800000 + (j == 0 ? 32'h0 : 32'h0);
        src[31:0]    = 32'h3F800000; src[63:32]   = 32'h40000000;
        src[95:64]   = 32'h40400000; src[127:96]  = 32'h40800000;
        src[159:128] = 32'h40A00000; src[191:160] = 32'h40C00000;
        src[223:192] = 32'h40E00000; src[255:224] = 32'h41000000;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill_old();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset result", result, '0);
        chk("R12 reset flags", {510'd0, flag_invalid, flag_precision}, '0);
        chk("R12 reset done", {511'd0, done}, '0);
        rst_n = 1'b1;

        // Table walk, two lanes, no mask
        for (int v = 0; v < NV; v++) begin
            src = {8{32'h3F800000}};
            src[31:0] = VECS[v].a;
            src[63:32] = VECS[v].b;
            rnd_global = VECS[v].rc;
            vlen_sel = 2'b00;
            fire();
            chk($sformatf("R%0d vec %0d lane0", VECS[v].req, v), {448'd0, lane(result, 0)}, {448'd0, VECS[v].ea});
            chk($sformatf("R%0d vec %0d lane1", VECS[v].req, v), {448'd0, lane(result, 1)}, {448'd0, VECS[v].eb});
            chk($sformatf("R11 vec %0d flags", v), {510'd0, flag_invalid, flag_precision},
                {510'd0, VECS[v].inv, VECS[v].prec});
            chk($sformatf("R1 vec %0d upper", v), {128'd0, result[511:128]}, '0);
        end

        // R12 done pulse and hold
        chk("R12 done high", {511'd0, done}, 512'd1);
        held = result;
        @(negedge clk);
        chk("R12 done low", {511'd0, done}, '0);
        chk("R12 result holds", result, held);

        // R1 four lanes with merge data present
        fill_ints();
        rnd_global = 2'd0;
        vlen_sel = 2'b01;
        fire();
        chk("R1 4-lane lane3", {448'd0, lane(result, 3)}, 512'd4);
        chk("R1 4-lane upper", {256'd0, result[511:256]}, '0);

        // R2 eight lanes
        vlen_sel = 2'b10;
        fire();
        for (int j = 0; j < 8; j++)
            chk($sformatf("R2 8-lane lane%0d", j), {448'd0, lane(result, j)}, 512'(j + 1));
        vlen_sel = 2'b11;
        fire();
        chk("R1 code 11 lane7", {448'd0, lane(result, 7)}, 512'd8);

        // R8 R9 merge masking
        vlen_sel = 2'b10; wmask_en = 1'b1; wmask = 8'b0000_0101; zero_fill = 1'b0;
        fire();
        chk("R8 merge lane0", {448'd0, lane(result, 0)}, 512'd1);
        chk("R8 merge lane2", {448'd0, lane(result, 2)}, 512'd3);
        chk("R9 merge lane1", {448'd0, lane(result, 1)}, {448'd0, lane(old_dst, 1)});
        chk("R9 merge lane7", {448'd0, lane(result, 7)}, {448'd0, lane(old_dst, 7)});
        // R9 zeroing
        zero_fill = 1'b1;
        fire();
        chk("R9 zero lane1", {448'd0, lane(result, 1)}, '0);
        chk("R9 zero lane2", {448'd0, lane(result, 2)}, 512'd3);
        // R8 unmasked lanes all written when mask off
        wmask_en = 1'b0; wmask = 8'h00;
        fire();
        chk("R8 mask off lane5", {448'd0, lane(result, 5)}, 512'd6);

        // R11 flags from masked lane ignored
        src[63:32] = 32'h7FC00000; src[95:64] = 32'h40200000;
        wmask_en = 1'b1; wmask = 8'b1111_1001;
        fire();
        chk("R11 masked flags", {510'd0, flag_invalid, flag_precision}, '0);
        wmask = 8'b0000_0010;
        fire();
        chk("R11 written invalid", {510'd0, flag_invalid, flag_precision}, 512'd2);
        wmask_en = 1'b0;

        // R10 broadcast from memory; R4 embedded ignored for memory
        src = {8{32'h3F800000}}; src[31:0] = 32'h40200000;
        src_is_mem = 1'b1; bcast_rnd = 1'b1; rnd_global = 2'd0; rnd_embed = 2'd2;
        fire();
        chk("R10 bcast lane6", {448'd0, lane(result, 6)}, 512'd2);
        chk("R4 mem uses global", {448'd0, lane(result, 0)}, 512'd2);
        src_is_mem = 1'b1; bcast_rnd = 1'b0;
        fire();
        chk("R10 no bcast lane6", {448'd0, lane(result, 6)}, 512'd1);

        // R4 register source full width: embedded rounding, no broadcast
        src_is_mem = 1'b0; bcast_rnd = 1'b1;
        fire();
        chk("R4 embed lane0", {448'd0, lane(result, 0)}, 512'd3);
        chk("R10 reg no bcast", {448'd0, lane(result, 4)}, 512'd1);
        vlen_sel = 2'b01;
        fire();
        chk("R4 short uses global", {448'd0, lane(result, 0)}, 512'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule